// File: doc/BRIEF.md
# Limit-Match System Counter Timer

This block is a free-standing interval timer for a chip's system tick. An up-counter advances by one step each time the `tick_en` strobe is high; the surrounding logic raises that strobe once every 500 ns. The count is exposed in register bits 30:9, so each step adds 0x200 to the value read, and bits 8:0 always read as zero. Software programs a limit. When the counter reaches a nonzero limit, the timer sets a sticky reached flag in bit 31 and raises a level interrupt. On the next step the counter restarts from zero, so a fixed limit produces a periodic interrupt. A limit of zero makes the counter free-run with no match.

The register interface is word addressed. Software writes the limit at one of two addresses. One address also restarts the count and lowers the interrupt. The other changes the limit and leaves the running count alone. Reading the limit register acknowledges the interrupt. Read data is registered.

Top module: `systmr_top`

## Requirements
- R1: Synchronous reset clears the count, the limit and the reached flag and drives `irq` low. After reset, reads of byte address 0x00 and 0x04 return zero.
- R2: Each cycle with `tick_en` high, and no restart in that cycle, adds 0x200 to the counter value read at 0x04. Bits 8:0 of every read are zero.
- R3: A write to 0x00 stores `wdata & 0x7FFFFE00` as the limit, restarts the count at zero and drives `irq` low from the next cycle on. It leaves the reached flag unchanged.
- R4: A write to 0x08 stores `wdata & 0x7FFFFE00` as the limit and leaves the count and `irq` untouched. The next ticks are compared with the new limit.
- R5: If a tick makes the count equal to a nonzero limit, the reached flag (bit 31 of the 0x04 read) is set and `irq` goes high at that same clock edge.
- R6: A tick while the count already equals the nonzero limit returns the count to zero without a new match. The interrupt therefore repeats every limit+1 ticks.
- R7: With a zero limit, the count runs up to its maximum (0x7FFFFE00 with 22 count bits) and wraps to zero. It never sets the reached flag or `irq`.
- R8: A read of 0x00 returns the limit with bit 31 clear, clears the reached flag and drives `irq` low.
- R9: A read of 0x04 returns the count in bits 30:9 with the reached flag in bit 31. A write to 0x04 has no effect.
- R10: Reads of any address other than 0x00 and 0x04 (including 0x08, 0x0C and 0x10) return zero. Writes to addresses other than 0x00 and 0x08 change nothing.
- R11: `rdata` updates at the clock edge that samples `rd_en` and holds its value until the next read.
- R12: If a match and a read of 0x00 fall in the same cycle, the match wins: the flag and `irq` are set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle strobe per 500 ns time step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt on limit match |

## Verification
The timer is driven with limits of several sizes: an all-ones write that checks masking, a five-step limit run through two full periods, and a three-step limit installed mid-count through 0x08. Together these separate restart from no-restart writes and show that a match happens at exactly the programmed step. A zero limit is run past the wrap point on a narrow-count copy of the block, which shows that free-run never matches. Reads, writes and ticks are placed in the same cycle, or in back-to-back cycles, to separate set-versus-clear priority, acknowledge by read from acknowledge by write, and held read data from live count.

// File: rtl/systmr_pkg.sv
package systmr_pkg;

    localparam int WORD_W   = 32;
    localparam int UNIT_LSB = 9;

    // word index taken from byte address bits 4:2
    typedef enum logic [2:0] {
        IDX_LIMIT      = 3'd0,
        IDX_COUNT      = 3'd1,
        IDX_LIMIT_KEEP = 3'd2,
        IDX_STATUS     = 3'd3,
        IDX_MODE       = 3'd4
    } reg_idx_e;

endpackage

// File: rtl/systmr_step.sv
module systmr_step #(
    parameter int CNT_W = 22
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] lim,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_d,
    output logic             hit
);

    logic [CNT_W-1:0] inc;
    logic             armed;
    logic             at_lim;

    always_comb begin
        inc    = cnt_q + CNT_W'(1);
        armed  = |lim;
        at_lim = armed && (cnt_q == lim);
        cnt_d  = cnt_q;
        hit    = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            if (at_lim) begin
                cnt_d = '0;
            end else begin
                cnt_d = inc;
                hit   = armed && (inc == lim);
            end
        end
    end

endmodule

// File: rtl/systmr_rdmux.sv
module systmr_rdmux
    import systmr_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  reg_idx_e          idx,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  lim,
    input  logic              reached,
    output logic [WORD_W-1:0] rd_val
);

    logic [WORD_W-2:0] cnt_f;
    logic [WORD_W-2:0] lim_f;

    assign cnt_f = (WORD_W-1)'(cnt) << UNIT_LSB;
    assign lim_f = (WORD_W-1)'(lim) << UNIT_LSB;

    always_comb begin
        case (idx)
            IDX_LIMIT: rd_val = {1'b0, lim_f};
            IDX_COUNT: rd_val = {reached, cnt_f};
            default:   rd_val = '0;
        endcase
    end

endmodule

// File: rtl/systmr_top.sv
module systmr_top
    import systmr_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);

    localparam logic [WORD_W-1:0] LIM_MASK =
        WORD_W'(((64'd1 << CNT_W) - 64'd1) << UNIT_LSB);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  lim;
        logic              reached;
        logic              irq;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t            st_q;
    state_t            st_d;
    reg_idx_e          idx;
    logic [WORD_W-1:0] wmask;
    logic [CNT_W-1:0]  lim_new;
    logic [CNT_W-1:0]  lim_eff;
    logic [CNT_W-1:0]  cnt_next;
    logic              hit;
    logic              wr_lim;
    logic              wr_keep;
    logic              rd_lim;
    logic [WORD_W-1:0] rd_val;

    assign idx     = reg_idx_e'(3'(addr >> 2));
    assign wmask   = wdata & LIM_MASK;
    assign lim_new = CNT_W'(wmask >> UNIT_LSB);
    assign wr_lim  = wr_en && (idx == IDX_LIMIT);
    assign wr_keep = wr_en && (idx == IDX_LIMIT_KEEP);
    assign rd_lim  = rd_en && (idx == IDX_LIMIT);
    assign lim_eff = (wr_lim || wr_keep) ? lim_new : st_q.lim;

    systmr_step #(.CNT_W(CNT_W)) u_step (
        .cnt_q   (st_q.cnt),
        .lim     (lim_eff),
        .tick    (tick_en),
        .restart (wr_lim),
        .cnt_d   (cnt_next),
        .hit     (hit)
    );

    systmr_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .idx     (idx),
        .cnt     (st_q.cnt),
        .lim     (st_q.lim),
        .reached (st_q.reached),
        .rd_val  (rd_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lim = lim_eff;
        st_d.cnt = cnt_next;
        if (rd_en) begin
            st_d.rdata = rd_val;
        end
        if (rd_lim) begin
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end
        if (wr_lim) begin
            st_d.irq = 1'b0;
        end
        if (hit) begin
            st_d.reached = 1'b1;
            st_d.irq     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign irq   = st_q.irq;

endmodule

// File: rtl/systmr_checker.sv
module systmr_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        wr_en,
    input logic        rd_en,
    input logic [2:0]  word_idx,
    input logic [31:0] rdata,
    input logic        irq
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && rdata == 32'd0));

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rdata[8:0] == 9'd0));

    p_limit_write_drops_irq_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word_idx == 3'd0) |=> !irq);

    p_irq_rises_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick_en));

    p_limit_read_acks_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && word_idx == 3'd0 && !tick_en) |=> (!irq && !rdata[31]));

    p_undefined_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && word_idx != 3'd0 && word_idx != 3'd1) |=> (rdata == 32'd0));

    p_rdata_held_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

bind systmr_top systmr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .word_idx (addr[4:2]),
    .rdata    (rdata),
    .irq      (irq)
);

// File: tb/systmr_top_bench.sv
module systmr_top_bench;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_TK  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [4:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 44;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD,  4'd1,  5'h04, 32'h0000_0000},  // R1
        '{OP_RD,  4'd1,  5'h00, 32'h0000_0000},  // R1
        '{OP_IRQ, 4'd1,  5'h00, 32'd0},          // R1
        '{OP_WR,  4'd3,  5'h00, 32'hFFFF_FFFF},  // R3 mask
        '{OP_RD,  4'd3,  5'h00, 32'h7FFF_FE00},  // R3
        '{OP_WR,  4'd3,  5'h00, 32'h8000_0BFF},  // R3 limit 5 steps
        '{OP_TK,  4'd2,  5'h00, 32'd3},          // R2
        '{OP_RD,  4'd2,  5'h04, 32'h0000_0600},  // R2
        '{OP_IRQ, 4'd5,  5'h00, 32'd0},          // R5
        '{OP_TK,  4'd5,  5'h00, 32'd2},          // R5
        '{OP_IRQ, 4'd5,  5'h00, 32'd1},          // R5
        '{OP_RD,  4'd9,  5'h04, 32'h8000_0A00},  // R9
        '{OP_TK,  4'd6,  5'h00, 32'd1},          // R6
        '{OP_RD,  4'd6,  5'h04, 32'h8000_0000},  // R6
        '{OP_RD,  4'd8,  5'h00, 32'h0000_0A00},  // R8
        '{OP_IRQ, 4'd8,  5'h00, 32'd0},          // R8
        '{OP_RD,  4'd8,  5'h04, 32'h0000_0000},  // R8
        '{OP_WR,  4'd9,  5'h04, 32'h0001_2345},  // R9 ignored
        '{OP_RD,  4'd9,  5'h04, 32'h0000_0000},  // R9
        '{OP_TK,  4'd6,  5'h00, 32'd5},          // R6 second period
        '{OP_IRQ, 4'd6,  5'h00, 32'd1},          // R6
        '{OP_WR,  4'd3,  5'h00, 32'h0000_0A00},  // R3
        '{OP_IRQ, 4'd3,  5'h00, 32'd0},          // R3
        '{OP_RD,  4'd3,  5'h04, 32'h8000_0000},  // R3 flag kept
        '{OP_RD,  4'd8,  5'h00, 32'h0000_0A00},  // R8
        '{OP_TK,  4'd2,  5'h00, 32'd2},          // R2
        '{OP_WR,  4'd4,  5'h08, 32'h0000_0600},  // R4
        '{OP_RD,  4'd4,  5'h04, 32'h0000_0400},  // R4
        '{OP_TK,  4'd4,  5'h00, 32'd1},          // R4
        '{OP_RD,  4'd4,  5'h04, 32'h8000_0600},  // R4
        '{OP_IRQ, 4'd4,  5'h00, 32'd1},          // R4
        '{OP_RD,  4'd8,  5'h00, 32'h0000_0600},  // R8
        '{OP_RD,  4'd10, 5'h08, 32'h0000_0000},  // R10
        '{OP_RD,  4'd10, 5'h0C, 32'h0000_0000},  // R10
        '{OP_RD,  4'd10, 5'h10, 32'h0000_0000},  // R10
        '{OP_RD,  4'd10, 5'h14, 32'h0000_0000},  // R10
        '{OP_RD,  4'd10, 5'h1C, 32'h0000_0000},  // R10
        '{OP_WR,  4'd10, 5'h0C, 32'hFFFF_FFFF},  // R10
        '{OP_WR,  4'd10, 5'h10, 32'hFFFF_FFFF},  // R10
        '{OP_WR,  4'd10, 5'h14, 32'hFFFF_FFFF},  // R10
        '{OP_WR,  4'd10, 5'h1C, 32'hFFFF_FFFF},  // R10
        '{OP_RD,  4'd10, 5'h04, 32'h0000_0600},  // R10
        '{OP_RD,  4'd10, 5'h00, 32'h0000_0600},  // R10
        '{OP_IRQ, 4'd10, 5'h00, 32'd0}           // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [31:0] rdata_s;
    logic        irq_s;
    int          n_checks = 0;
    int          n_errors = 0;

    always #10 clk = ~clk;

    systmr_top u_systmr_top (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    systmr_top #(.CNT_W(3)) u_systmr_top_small (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_s), .irq(irq_s)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [4:0] a);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", VECS[k].req, k);
            case (VECS[k].op)
                OP_WR:  do_wr(VECS[k].addr, VECS[k].data);
                OP_RD:  begin do_rd(VECS[k].addr); check(tag, rdata, VECS[k].data); end
                OP_TK:  do_tick(int'(VECS[k].data));
                default: check(tag, {31'd0, irq}, VECS[k].data);
            endcase
        end

        // R11: read data held while the count moves
        do_rd(5'h04);
        check("R11 read count", rdata, 32'h0000_0600);
        do_tick(1);
        check("R11 rdata held", rdata, 32'h0000_0600);
        do_rd(5'h04);
        check("R6 count back to zero", rdata, 32'h0000_0000);

        // R12: match and limit read in the same cycle
        do_tick(2);
        tick_en = 1'b1; rd_en = 1'b1; addr = 5'h00;
        @(posedge clk); @(negedge clk);
        tick_en = 1'b0; rd_en = 1'b0;
        check("R12 limit value", rdata, 32'h0000_0600);
        check("R12 irq set wins", {31'd0, irq}, 32'd1);
        do_rd(5'h04);
        check("R12 flag set wins", rdata, 32'h8000_0600);
        do_rd(5'h00);

        // R7: free-run, wrap shown on the 3-bit instance
        do_wr(5'h00, 32'h0000_0000);
        do_tick(7);
        do_rd(5'h04);
        check("R7 wide count", rdata, 32'h0000_0E00);
        check("R7 narrow at max", rdata_s, 32'h0000_0E00);
        do_tick(1);
        do_rd(5'h04);
        check("R7 wide keeps counting", rdata, 32'h0000_1000);
        check("R7 narrow wrapped", rdata_s, 32'h0000_0000);
        check("R7 no irq wide", {31'd0, irq}, 32'd0);
        check("R7 no irq narrow", {31'd0, irq_s}, 32'd0);

        // R1: reset in the middle of a run
        do_wr(5'h00, 32'h0000_0A00);
        do_tick(5);
        check("R5 irq before reset", {31'd0, irq}, 32'd1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 irq cleared by reset", {31'd0, irq}, 32'd0);
        do_rd(5'h00);
        check("R1 limit cleared", rdata, 32'd0);
        do_rd(5'h04);
        check("R1 count cleared", rdata, 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule